// File: doc/BRIEF.md
# Configurable Logic Cell with Dual Lookup Tables

This block is one programmable cell of an SRAM-configured logic fabric. It holds two 4-input lookup tables, here called the F table and the G table. Each one gives any Boolean function of its four inputs. A 3-input merge table, H, combines the two table outputs with one extra input. Two combinational outputs and two storage elements pick their data from these function results or from a direct data pin.

Each storage element can be set up on its own in several ways:
- as an edge-triggered flip-flop or as a transparent latch;
- with a chosen clock sense;
- with a clock enable;
- with a set/reset pin that can act synchronously or asynchronously, and that forces either a 1 or a 0.

Either lookup table can also be turned into a 16x1 RAM. In that mode it is written on the rising clock edge, and its four function inputs serve as the address.

Configuration enters through a plain serial shift port, one bit per rising clock edge while shifting is enabled. The cell has no streaming data path. Configuration and RAM writes use plain control pins with no back-pressure: every bit offered while the enable is high is taken on that edge.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `cfg_en` is high, each rising `clk` edge shifts `cfg_din` into a 58-bit configuration word, entering at the LSB, so the first bit shifted ends up as bit 57. Without `cfg_en` and without a RAM write, the word holds its value. The word is laid out from bit 57 down as follows:
  - F table, 16 bits, with the table bit for address a at bit 42+a;
  - G table, 16 bits, with the bit for address a at bit 26+a;
  - H table, 8 bits, with the bit for index i at bit 18+i;
  - X storage field, 6 bits at [17:12];
  - Y storage field, 6 bits at [11:6];
  - X output select at [5:4];
  - Y output select at [3:2];
  - F RAM mode at bit 1;
  - G RAM mode at bit 0.
- R2: The F result equals the F table bit addressed by `f_in`, and the G result equals the G table bit addressed by `g_in`. This holds for any table contents.
- R3: The H result equals the H table bit at index {h1, G result, F result}, with `h1` as the MSB.
- R4: Outputs `x` and `y` follow their 2-bit select codes: 0 gives F, 1 gives G, 2 gives H, 3 gives `din`.
- R5: When a table's RAM-mode bit is 1 and `ram_we` is high (with `cfg_en` low), the rising `clk` edge writes `ram_wd` into that table at the address on its inputs. Before that edge, a read of the same address returns the old bit. When the RAM-mode bit is 0, `ram_we` has no effect.
- R6: In flip-flop mode (latch bit 0), a storage element captures its data on the rising `clk` edge when its clock-invert bit is 0, and on the falling edge when that bit is 1. It captures only when its `ce` bit is high, and holds otherwise.
- R7: In latch mode (latch bit 1), a storage element is transparent while `clk` is high (invert 0) or low (invert 1) and its `ce` bit is high. At all other times it holds.
- R8: Each storage field is {data select[5:4], latch[3], clock invert[2], set/reset value[1], synchronous[0]}. The data select uses the codes of R4.
- R9: With the synchronous bit at 0, a high `sr` forces the storage element to its set/reset value at once, whatever the clock and `ce` are doing.
- R10: With the synchronous bit at 1, a high `sr` forces the set/reset value only at an active capture edge or transparent phase with `ce` high. With `ce` low it has no effect.
- R11: A low `rst_n` clears the configuration word and both storage elements to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, used for configuration shifting, RAM writes and storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit, MSB first |
| f_in | input | 4 | F table inputs, also the F RAM address |
| g_in | input | 4 | G table inputs, also the G RAM address |
| h1 | input | 1 | Extra input of the H merge table |
| din | input | 1 | Direct data input |
| sr | input | 1 | Set/reset request shared by both storage elements |
| ce | input | 2 | Clock enables: bit 0 for the X element, bit 1 for the Y element |
| ram_we | input | 1 | RAM write enable |
| ram_wd | input | 1 | RAM write data |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | X storage element output |
| yq | output | 1 | Y storage element output |

## Verification
The assertions check four things on every rising edge:
- each shift moves the configuration word by one place;
- the word holds when it is neither shifted nor written;
- the F result always matches the table bit its inputs address;
- a RAM write lands at the sampled address, and an asynchronous set/reset holds the X storage element at its configured value while the request stays high.

Only the bench scenarios can show the rest. These are the capture points of falling-edge flip-flops and of latches on both clock senses, the read-before-write timing of the RAM, and the refusal of a synchronous set/reset while the clock enable is low. The bench also sweeps every H merge combination, and shows that RAM writes are ignored when RAM mode is off.

// File: rtl/clc_pkg.sv
package clc_pkg;
  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } src_sel_e;

  // Per-storage-element configuration field
  typedef struct packed {
    src_sel_e dsel;
    logic     latch_mode;
    logic     clk_inv;
    logic     sr_val;
    logic     sr_sync;
  } store_cfg_t;

  localparam int STORE_CFG_W = $bits(store_cfg_t);
  localparam int H_K = 3;
  localparam int H_N = 1 << H_K;
endpackage

// File: rtl/clc_lut_read.sv
module clc_lut_read #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tbl,
  input  logic [K-1:0] sel,
  output logic         o
);
  assign o = tbl[sel];
endmodule

// File: rtl/clc_cfg_chain.sv
module clc_cfg_chain #(
  parameter int CFG_W = 58,
  parameter int LUT_K = 4,
  parameter int F_LO  = 42,
  parameter int G_LO  = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_in,
  input  logic             f_we,
  input  logic [LUT_K-1:0] f_addr,
  input  logic             g_we,
  input  logic [LUT_K-1:0] g_addr,
  input  logic             wd,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= {cfg_q[CFG_W-2:0], shift_in};
    end else begin
      if (f_we) cfg_q[F_LO + int'(f_addr)] <= wd;
      if (g_we) cfg_q[G_LO + int'(g_addr)] <= wd;
    end
  end
endmodule

// File: rtl/clc_store.sv
module clc_store (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic ce,
  input  logic sr,
  input  logic latch_mode,
  input  logic clk_inv,
  input  logic sr_val,
  input  logic sr_sync,
  output logic q
);
  logic eclk, async_hit, next_d, ff_q, lat_q;

  assign eclk      = clk ^ clk_inv;
  assign async_hit = sr & ~sr_sync;
  assign next_d    = (sr & sr_sync) ? sr_val : d;

  always_ff @(posedge eclk or negedge rst_n or posedge async_hit) begin
    if (!rst_n)         ff_q <= 1'b0;
    else if (async_hit) ff_q <= sr_val;
    else if (ce)        ff_q <= next_d;
  end

  always_latch begin
    if (!rst_n)             lat_q <= 1'b0;
    else if (async_hit)     lat_q <= sr_val;
    else if (eclk && ce)    lat_q <= next_d;
  end

  assign q = latch_mode ? lat_q : ff_q;
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import clc_pkg::*;
#(
  parameter int LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             h1,
  input  logic             din,
  input  logic             sr,
  input  logic [1:0]       ce,
  input  logic             ram_we,
  input  logic             ram_wd,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  localparam int LUT_N  = 1 << LUT_K;
  localparam int SEL_LO = 2;
  localparam int XS_LO  = SEL_LO + 2;
  localparam int R1_LO  = XS_LO + 2;
  localparam int R0_LO  = R1_LO + STORE_CFG_W;
  localparam int H_LO   = R0_LO + STORE_CFG_W;
  localparam int G_LO   = H_LO + H_N;
  localparam int F_LO   = G_LO + LUT_N;
  localparam int CFG_W  = F_LO + LUT_N;

  logic [CFG_W-1:0] cfg_q;
  logic             f_out, g_out, h_out;
  logic             f_ram, g_ram;
  logic [1:0]       xsel, ysel;
  logic [3:0]       src;
  logic [1:0]       qv;
  store_cfg_t       scfg [2];

  assign f_ram   = cfg_q[1];
  assign g_ram   = cfg_q[0];
  assign ysel    = cfg_q[SEL_LO +: 2];
  assign xsel    = cfg_q[XS_LO +: 2];
  assign scfg[0] = store_cfg_t'(cfg_q[R0_LO +: STORE_CFG_W]);
  assign scfg[1] = store_cfg_t'(cfg_q[R1_LO +: STORE_CFG_W]);

  clc_cfg_chain #(.CFG_W(CFG_W), .LUT_K(LUT_K), .F_LO(F_LO), .G_LO(G_LO)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_in (cfg_din),
    .f_we     (ram_we & f_ram),
    .f_addr   (f_in),
    .g_we     (ram_we & g_ram),
    .g_addr   (g_in),
    .wd       (ram_wd),
    .cfg_q    (cfg_q)
  );

  clc_lut_read #(.K(LUT_K)) u_flut (.tbl(cfg_q[F_LO +: LUT_N]), .sel(f_in), .o(f_out));
  clc_lut_read #(.K(LUT_K)) u_glut (.tbl(cfg_q[G_LO +: LUT_N]), .sel(g_in), .o(g_out));
  clc_lut_read #(.K(H_K))   u_hlut (.tbl(cfg_q[H_LO +: H_N]),
                                    .sel({h1, g_out, f_out}), .o(h_out));

  assign src = {din, h_out, g_out, f_out};
  assign x   = src[xsel];
  assign y   = src[ysel];

  for (genvar i = 0; i < 2; i++) begin : g_store
    clc_store u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .d          (src[scfg[i].dsel]),
      .ce         (ce[i]),
      .sr         (sr),
      .latch_mode (scfg[i].latch_mode),
      .clk_inv    (scfg[i].clk_inv),
      .sr_val     (scfg[i].sr_val),
      .sr_sync    (scfg[i].sr_sync),
      .q          (qv[i])
    );
  end

  assign xq = qv[0];
  assign yq = qv[1];
endmodule

// File: rtl/clc_chk.sv
module clc_chk #(
  parameter int CFG_W = 58,
  parameter int LUT_K = 4,
  parameter int F_LO  = 42,
  parameter int R0_LO = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic             ram_we,
  input logic             ram_wd,
  input logic [LUT_K-1:0] f_in,
  input logic             sr,
  input logic             xq,
  input logic             f_out,
  input logic [CFG_W-1:0] cfg_q
);
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din)});

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !ram_we) |=> cfg_q == $past(cfg_q));

  p_lut_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    f_out == cfg_q[F_LO + int'(f_in)]);

  p_ram_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && ram_we && cfg_q[1]) |=> cfg_q[F_LO + int'($past(f_in))] == $past(ram_wd));

  p_async_sr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && !cfg_q[R0_LO]) |-> xq == cfg_q[R0_LO + 1]);
endmodule

bind cfg_logic_cell clc_chk #(.CFG_W(CFG_W), .LUT_K(LUT_K), .F_LO(F_LO), .R0_LO(R0_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .ram_we(ram_we),
  .ram_wd(ram_wd), .f_in(f_in), .sr(sr), .xq(xq), .f_out(f_out), .cfg_q(cfg_q)
);

// File: tb/cfg_logic_cell_bench.sv
`timescale 1ns/1ps
module cfg_logic_cell_bench;
  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
  logic [3:0] f_in = '0, g_in = '0;
  logic h1 = 1'b0, din = 1'b0, sr = 1'b0, ram_we = 1'b0, ram_wd = 1'b0;
  logic [1:0] ce = 2'b00;
  logic x, y, xq, yq;
  int total = 0, bad = 0;
  logic [15:0] ft, gt;
  logic [7:0] ht;

  always #4 clk = ~clk;

  cfg_logic_cell u_cfg_logic_cell (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // field: {dsel[1:0], latch, inv, srval, srsync}
  function automatic logic [57:0] mk(input logic [15:0] f, input logic [15:0] g,
    input logic [7:0] h, input logic [5:0] r0, input logic [5:0] r1,
    input logic [1:0] xs, input logic [1:0] ys, input logic fr, input logic gr);
    return {f, g, h, r0, r1, xs, ys, fr, gr};
  endfunction

  task automatic load(input logic [57:0] w);
    @(posedge clk); #1;
    for (int i = 57; i >= 0; i--) begin
      cfg_en = 1'b1; cfg_din = w[i];
      tick();
    end
    cfg_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog all-reqs actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20;
    chk("R11 reset xq", xq, 1'b0); chk("R11 reset yq", yq, 1'b0);
    chk("R11 reset x", x, 1'b0);   chk("R11 reset y", y, 1'b0);
    tick(); rst_n = 1'b1;

    // R1 R2: two table pairs, exhaustive
    for (int p = 0; p < 2; p++) begin
      ft = p ? 16'h8000 : 16'h6A3C;
      gt = p ? 16'h7FFE : 16'hB1E4;
      load(mk(ft, gt, 8'h00, 6'd0, 6'd0, 2'd0, 2'd1, 1'b0, 1'b0));
      for (int a = 0; a < 16; a++) begin
        f_in = 4'(a); g_in = 4'(15 - a); #1;
        chk("R2 F table via x (R1 layout)", x, ft[a]);
        chk("R2 G table via y (R1 layout)", y, gt[15 - a]);
      end
    end

    // R3 R4: H merge exhaustive, y = din
    ft = 16'h6A3C; gt = 16'hB1E4; ht = 8'hD2;
    load(mk(ft, gt, ht, 6'd0, 6'd0, 2'd2, 2'd3, 1'b0, 1'b0));
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          f_in = 4'(a); g_in = 4'(b); h1 = c[0]; din = a[0] ^ b[1]; #1;
          chk("R3 H merge", x, ht[{c[0], gt[b], ft[a]}]);
          chk("R4 y selects din", y, a[0] ^ b[1]);
        end
    h1 = 1'b0;

    // R5: RAM mode on both tables
    ft = 16'h0000; gt = 16'hFFFF;
    load(mk(ft, gt, 8'h00, 6'd0, 6'd0, 2'd0, 2'd1, 1'b1, 1'b1));
    for (int a = 0; a < 16; a++) begin
      logic p;
      p = a[0] ^ a[2] ^ a[3];
      f_in = 4'(a); g_in = 4'(15 - a); ram_wd = p; ram_we = 1'b1; #1;
      chk("R5 read before write F", x, ft[a]);
      chk("R5 read before write G", y, gt[15 - a]);
      tick();
      chk("R5 written F", x, p);
      chk("R5 written G", y, p);
      ft[a] = p; gt[15 - a] = p;
      ram_we = 1'b0;
    end
    for (int a = 0; a < 16; a++) begin
      f_in = 4'(a); g_in = 4'(a); #1;
      chk("R5 readback F", x, ft[a]);
      chk("R5 readback G", y, gt[a]);
    end
    // R5: RAM mode off ignores writes
    ft = 16'h0F0F;
    load(mk(ft, 16'h0, 8'h00, 6'd0, 6'd0, 2'd0, 2'd1, 1'b0, 1'b0));
    f_in = 4'd3; ram_wd = ~ft[3]; ram_we = 1'b1; tick(); ram_we = 1'b0; #1;
    chk("R5 write ignored when RAM off", x, ft[3]);

    // R6 R8: x ff rising from din, y ff falling from F
    ft = 16'h00F0;
    ce = 2'b11;
    load(mk(ft, 16'h0, 8'h00, 6'b11_0_0_0_0, 6'b00_0_1_0_0, 2'd0, 2'd1, 1'b0, 1'b0));
    din = 1'b0; f_in = 4'd0; tick(); tick();
    chk("R6 ff rising init", xq, 1'b0); chk("R6 ff falling init", yq, 1'b0);
    din = 1'b1; f_in = 4'd5; #1;
    chk("R6 ff rising before edge", xq, 1'b0);
    #2; chk("R6 ff falling before negedge", yq, 1'b0);
    #2; chk("R8 ff falling captured F", yq, 1'b1);
    tick(); chk("R6 ff rising captured", xq, 1'b1);
    ce = 2'b00; din = 1'b0; f_in = 4'd0; tick(); tick();
    chk("R6 ce low holds x", xq, 1'b1); chk("R6 ce low holds y", yq, 1'b1);

    // R7: x latch transparent high, y latch transparent low, both from din
    ce = 2'b11;
    load(mk(ft, 16'h0, 8'h00, 6'b11_1_0_0_0, 6'b11_1_1_0_0, 2'd0, 2'd1, 1'b0, 1'b0));
    din = 1'b1; #1;
    chk("R7 high latch transparent", xq, 1'b1);
    chk("R7 low latch holds in high phase", yq, 1'b0);
    #4; chk("R7 low latch transparent", yq, 1'b1);
    din = 1'b0; #1;
    chk("R7 high latch holds in low phase", xq, 1'b1);
    chk("R7 low latch follows", yq, 1'b0);
    tick(); chk("R7 high latch follows again", xq, 1'b0);

    // R9: async set, ff, ce low
    ce = 2'b00;
    load(mk(ft, 16'h0, 8'h00, 6'b11_0_0_1_0, 6'b11_0_0_0_0, 2'd0, 2'd1, 1'b0, 1'b0));
    ce = 2'b01; din = 1'b0; tick(); tick(); ce = 2'b00;
    chk("R9 before async set", xq, 1'b0);
    sr = 1'b1; #1;
    chk("R9 async set immediate", xq, 1'b1);
    sr = 1'b0; ce = 2'b01; tick(); tick();
    chk("R9 released, din captured", xq, 1'b0);

    // R10: sync reset, ff
    load(mk(ft, 16'h0, 8'h00, 6'b11_0_0_0_1, 6'b11_0_0_0_0, 2'd0, 2'd1, 1'b0, 1'b0));
    din = 1'b1; ce = 2'b01; tick(); tick();
    chk("R10 setup", xq, 1'b1);
    sr = 1'b1; #1;
    chk("R10 no effect before edge", xq, 1'b1);
    ce = 2'b00; tick(); tick();
    chk("R10 ignored with ce low", xq, 1'b1);
    ce = 2'b01; tick();
    chk("R10 sync reset at edge", xq, 1'b0);
    sr = 1'b0;

    // R8: x from G, y from H
    ft = 16'h0002; gt = 16'h0004; ht = 8'b0000_1000;
    load(mk(ft, gt, ht, 6'b01_0_0_0_0, 6'b10_0_0_0_0, 2'd0, 2'd1, 1'b0, 1'b0));
    ce = 2'b11; f_in = 4'd1; g_in = 4'd2; h1 = 1'b0; tick(); tick();
    chk("R8 x reg takes G", xq, 1'b1);
    chk("R8 y reg takes H", yq, 1'b1);
    f_in = 4'd0; tick(); tick();
    chk("R8 x reg G unchanged", xq, 1'b1);
    chk("R8 y reg H drops", yq, 1'b0);

    // R11: reset clears config and storage
    f_in = 4'd1; g_in = 4'd2; tick(); tick();
    rst_n = 1'b0; #1;
    chk("R11 reset clears xq", xq, 1'b0);
    chk("R11 reset clears config (x)", x, 1'b0);
    tick(); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule